// File: doc/BRIEF.md
# Frame-Counted Streaming Multiply-Accumulator

This block multiplies two signed scalar operands on every cycle that carries a valid strobe and adds the product to a running sum. A frame is a fixed number of valid samples, set by the `N_SAMPLES` parameter. An internal sample counter finds the frame boundaries, so no start or end strobe is needed. Each output cycle shows four things: the registered running sum, a delayed copy of the valid strobe, the position of the sample within its frame (1 to `N_SAMPLES`), and a one-cycle end-of-frame pulse on the last sample.

Cycles without a valid strobe are gaps. During a gap the sum and the position stay frozen. A gap does not break the frame. Once a frame completes, the next valid sample opens a new one and loads the sum with its own product. The accumulator is sized so that a full frame of worst-case products never wraps.

Top module: `mac_count_stream`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the outputs settle after a clock edge to `data_out` = 0, `count_out` = 1, `valid_out` = 0 and `end_out` = 0.
- R2: `valid_out` equals `valid_in` delayed by exactly one clock cycle.
- R3: A valid sample that opens a frame makes `data_out` equal to the signed product `a_in*b_in` one cycle later. This product replaces any earlier sum.
- R4: Any other valid sample makes `data_out`, one cycle later, equal to the previous `data_out` plus the signed product of that sample's operands.
- R5: On the cycle after a valid sample, `count_out` gives the sample's position in its frame. The first sample of a frame shows 1, and each later valid sample shows one more than the one before, up to `N_SAMPLES`.
- R6: `end_out` is high for exactly one cycle after the `N_SAMPLES`-th valid sample of a frame. That cycle is the one in which `count_out` equals `N_SAMPLES` and `valid_out` is high. `end_out` is low in every other cycle.
- R7: After a cycle with `valid_in` low, `data_out` keeps its value and `valid_out` and `end_out` are low. If a frame is part-way through, `count_out` keeps its value.
- R8: After a frame completes, an idle cycle brings `count_out` back to 1. The next valid sample starts a new frame at position 1.
- R9: The sum is `ACC_W` = `A_W`+`B_W`+ceil(log2(`N_SAMPLES`)) bits wide and signed. A full frame of the most negative operands gives the exact positive total, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operands are valid this cycle |
| a_in | input | A_W | First signed operand |
| b_in | input | B_W | Second signed operand |
| data_out | output | ACC_W | Registered signed running sum |
| valid_out | output | 1 | `data_out` was updated by a valid sample |
| end_out | output | 1 | Last sample of a frame |
| count_out | output | ceil(log2(N_SAMPLES+1)) | Position of the sample within its frame |

## Verification
Suppose the frame-open flag or the position register goes wrong. The fault shows on the very next valid sample. `count_out` steps to the wrong value, and `data_out` either adds to a stale sum or drops the current one. Both are visible one cycle after the sample. A lost or doubled end-of-frame decision is visible the same way. It also shows at the boundary: an end pulse appears early or late, and the following frame starts from a wrong sum.

Gaps are placed inside frames and right after frame ends, so an error that only shifts timing is still seen. The stimulus also runs frames back to back with no gap, and it drives extreme operand values. These two cases catch a sum that is not reloaded and a sum register that is too narrow.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Width of a signed sum of n products of aw-bit and bw-bit operands.
  function automatic int acc_width(input int aw, input int bw, input int n);
    return aw + bw + ((n > 1) ? $clog2(n) : 0);
  endfunction

  // Width able to hold the values 1..n.
  function automatic int count_width(input int n);
    return (n > 1) ? $clog2(n + 1) : 1;
  endfunction

endpackage

// File: rtl/mac_frame_counter.sv
module mac_frame_counter #(
  parameter int N_SAMPLES = 2,
  parameter int CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_i,
  output logic             first_o,
  output logic             last_o,
  output logic [CNT_W-1:0] cnt_q,
  output logic             end_q
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(N_SAMPLES);
  localparam logic [CNT_W-1:0] ONE_POS  = CNT_W'(1);

  logic             frame_open_q;
  logic [CNT_W-1:0] next_pos;

  assign next_pos = frame_open_q ? cnt_q + ONE_POS : ONE_POS;
  assign first_o  = !frame_open_q;
  assign last_o   = (next_pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= ONE_POS;
      frame_open_q <= 1'b0;
      end_q        <= 1'b0;
    end else if (sample_i) begin
      cnt_q        <= next_pos;
      frame_open_q <= !last_o;
      end_q        <= last_o;
    end else begin
      end_q <= 1'b0;
      if (!frame_open_q) cnt_q <= ONE_POS;
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= ONE_POS) && (cnt_q <= LAST_POS)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (sample_i && frame_open_q) |=> (cnt_q == $past(cnt_q) + ONE_POS)); // R5

  AST_COUNT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!sample_i && frame_open_q) |=> $stable(cnt_q)); // R7

  AST_RESTART_ONE: assert property (@(posedge clk) disable iff (rst)
    (end_q && !sample_i) |=> (cnt_q == ONE_POS)); // R8

  AST_END_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    end_q |-> (cnt_q == LAST_POS)); // R6

endmodule

// File: rtl/mac_product.sv
module mac_product #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  parameter int P_W = 32
) (
  input  logic [A_W-1:0]        a_i,
  input  logic [B_W-1:0]        b_i,
  output logic signed [P_W-1:0] prod_o
);

  logic signed [P_W-1:0] a_ext;
  logic signed [P_W-1:0] b_ext;

  assign a_ext  = P_W'($signed(a_i));
  assign b_ext  = P_W'($signed(b_i));
  assign prod_o = a_ext * b_ext;

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int P_W   = 32,
  parameter int ACC_W = 33
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_i,
  input  logic                    restart_i,
  input  logic signed [P_W-1:0]   prod_i,
  output logic signed [ACC_W-1:0] acc_q
);

  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] acc_next;

  assign prod_ext = ACC_W'(prod_i);
  assign acc_next = restart_i ? prod_ext : acc_q + prod_ext;

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= '0;
    else if (sample_i) acc_q <= acc_next;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sample_i |=> $stable(acc_q)); // R7

  AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (sample_i && restart_i) |=> (acc_q == $past(prod_ext))); // R3

  AST_ADD_ON: assert property (@(posedge clk) disable iff (rst)
    (sample_i && !restart_i) |=> (acc_q == $past(acc_q) + $past(prod_ext))); // R4

endmodule

// File: rtl/mac_count_stream.sv
module mac_count_stream
  import mac_pkg::*;
#(
  parameter int A_W       = 16,
  parameter int B_W       = 16,
  parameter int N_SAMPLES = 2,
  localparam int P_W      = A_W + B_W,
  localparam int ACC_W    = acc_width(A_W, B_W, N_SAMPLES),
  localparam int CNT_W    = count_width(N_SAMPLES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_in,
  input  logic [A_W-1:0]          a_in,
  input  logic [B_W-1:0]          b_in,
  output logic signed [ACC_W-1:0] data_out,
  output logic                    valid_out,
  output logic                    end_out,
  output logic [CNT_W-1:0]        count_out
);

  logic                  sample_fire;
  logic                  frame_first;
  logic                  frame_last;
  logic signed [P_W-1:0] product;
  logic                  valid_q;

  assign sample_fire = valid_in;

  mac_frame_counter #(.N_SAMPLES(N_SAMPLES), .CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .sample_i (sample_fire),
    .first_o  (frame_first),
    .last_o   (frame_last),
    .cnt_q    (count_out),
    .end_q    (end_out)
  );

  mac_product #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_product (
    .a_i    (a_in),
    .b_i    (b_in),
    .prod_o (product)
  );

  mac_accum #(.P_W(P_W), .ACC_W(ACC_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .sample_i  (sample_fire),
    .restart_i (frame_first),
    .prod_i    (product),
    .acc_q     (data_out)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= sample_fire;
  end
  assign valid_out = valid_q;

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    valid_out == $past(valid_in)); // R2

  AST_END_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    end_out |-> valid_out); // R6

  AST_END_FROM_LAST: assert property (@(posedge clk) disable iff (rst)
    (sample_fire && frame_last) |=> end_out); // R6

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!valid_out && !end_out && data_out == '0)); // R1

endmodule

// File: tb/tb_mac_count_stream.sv
module tb_mac_count_stream;

  localparam int AW  = 8;
  localparam int BW  = 8;
  localparam int NS  = 5;
  localparam int AC  = AW + BW + $clog2(NS);
  localparam int CW  = $clog2(NS + 1);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 valid_in = 1'b0;
  logic [AW-1:0]        a_in = '0;
  logic [BW-1:0]        b_in = '0;
  logic signed [AC-1:0] data_out;
  logic                 valid_out;
  logic                 end_out;
  logic [CW-1:0]        count_out;

  always #2.5 clk = ~clk;

  mac_count_stream #(.A_W(AW), .B_W(BW), .N_SAMPLES(NS)) dut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .a_in(a_in), .b_in(b_in),
    .data_out(data_out), .valid_out(valid_out), .end_out(end_out),
    .count_out(count_out)
  );

  typedef struct {
    bit    v;
    bit    e;
    int    cnt;
    int    data;
    string dtag;
    string ctag;
  } exp_t;

  exp_t  q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  int    m_sum    = 0;
  int    m_taken  = 0;
  int    m_cnt    = 1;
  bit    extreme  = 1'b0;
  bit    done     = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int a, input int b);
    exp_t it;
    @(negedge clk);
    valid_in = v;
    a_in     = AW'(a);
    b_in     = BW'(b);
    if (v) begin
      it.dtag = (m_taken == 0) ? "R3" : "R4";
      if (extreme) it.dtag = "R9";
      if (m_taken == 0) m_sum = a * b;
      else              m_sum = m_sum + a * b;
      m_taken++;
      m_cnt = m_taken;
      it.e  = (m_taken == NS);
      it.ctag = "R5";
      if (m_taken == NS) m_taken = 0;
    end else begin
      it.dtag = "R7";
      it.ctag = (m_taken == 0 && m_cnt == NS) ? "R8" : "R7";
      if (m_taken == 0) m_cnt = 1;
      it.e = 1'b0;
    end
    it.v    = v;
    it.cnt  = m_cnt;
    it.data = m_sum;
    q.push_back(it);
  endtask

  // Monitor: compare each registered result one step after its input.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk("R2", "valid_out", int'(valid_out), int'(it.v));
        chk("R6", "end_out", int'(end_out), int'(it.e));
        chk(it.ctag, "count_out", int'(count_out), it.cnt);
        chk(it.dtag, "data_out", int'(data_out), it.data);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "data_out reset", int'(data_out), 0);
    chk("R1", "count_out reset", int'(count_out), 1);
    chk("R1", "valid_out reset", int'(valid_out), 0);
    chk("R1", "end_out reset", int'(end_out), 0);
    @(negedge clk);
    rst = 1'b0;

    // idle before any sample: count stays 1 (R7)
    repeat (3) drive(1'b0, 0, 0);

    // contiguous frame (R3, R4, R5, R6)
    drive(1'b1, 1, 1);
    drive(1'b1, 2, 2);
    drive(1'b1, -3, 4);
    drive(1'b1, 7, -5);
    drive(1'b1, 10, 10);
    // idle after end: count returns to 1 (R8)
    drive(1'b0, 9, 9);
    drive(1'b0, 9, 9);

    // frame with gaps inside (R7)
    drive(1'b1, 3, 3);
    drive(1'b0, 50, 50);
    drive(1'b1, -4, 6);
    drive(1'b0, 1, 1);
    drive(1'b0, 1, 1);
    drive(1'b1, 12, 2);
    drive(1'b1, 5, 5);
    drive(1'b0, 0, 0);
    drive(1'b1, -1, -1);
    drive(1'b0, 0, 0);

    // back-to-back frames without idle: restart replaces sum (R3, R8)
    for (int i = 0; i < 2 * NS; i++) drive(1'b1, i + 3, 2 * i - 7);
    drive(1'b0, 0, 0);

    // extreme operands: no wrap (R9)
    extreme = 1'b1;
    for (int i = 0; i < NS; i++) drive(1'b1, -128, -128);
    for (int i = 0; i < NS; i++) drive(1'b1, -128, 127);
    extreme = 1'b0;
    drive(1'b0, 0, 0);

    // pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[3], $signed(lfsr[15:8]), $signed(lfsr[11:4]));
    end
    drive(1'b0, 0, 0);

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule